// File: doc/BRIEF.md
# Periodic Nonlinearity Correction for Time Measurements

This block takes a stream of raw time-to-digital measurements and removes a fixed integral nonlinearity that repeats once per reference clock period. The disturbance comes from the core clock coupling into the fine time interpolator, so it depends only on where a hit falls within one clock period. With a bin of about 97.66 ps and a 25 ns period, one period spans 256 bins. The low eight bits of each measurement therefore address a table of signed offsets, and the selected offset is added to the raw code.

The table holds one entry for every bin rather than one per group of bins. This lets it describe fine structure such as the extra artefact that appears every 32 bins. Offsets are written through a simple write port, and that port may be used while samples are streaming. Each result is rounded to the nearest whole count and clamped to the legal code range. A bypass control passes raw codes through unchanged for calibration runs. Producing the offsets from a code-density histogram is done elsewhere.

Top module: `inl_corrector`

## Requirements
- R1: After reset every table entry is zero, `out_valid` is low and `out_data` is zero, so a sample sent before any table write comes out equal to its raw value.
- R2: A sample presented with `in_valid` high at rising edge k appears on `out_data` with `out_valid` high after rising edge k+1 (two register stages). `out_valid` is low for every cycle that carries no sample.
- R3: The table entry is chosen by `in_data[7:0]` alone. Each of the 256 bins has its own independent entry, and the upper bits never affect which entry is used.
- R4: An entry is an 8-bit two's complement value with 4 fractional bits, so 16 means one count. The corrected code is floor((raw*16 + coef + 8) / 16), which rounds halves toward larger codes.
- R5: A corrected value below zero is output as 0 and never wraps.
- R6: A corrected value above 2^19-1 is output as 2^19-1 and never wraps.
- R7: A sample that arrives with `bypass` high is output equal to its raw value, whatever its table entry. `bypass` is taken per sample.
- R8: A table write at rising edge k is not seen by a sample accepted at the same edge, and is used by every sample accepted at edge k+1 or later.
- R9: `out_data` holds its last value through cycles in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Pass this sample through uncorrected |
| tbl_wr_en | input | 1 | Write one table entry this cycle |
| tbl_wr_addr | input | 8 | Bin index of the entry being written |
| tbl_wr_coef | input | 8 | Signed offset, 4 fractional bits |
| in_valid | input | 1 | `in_data` carries a sample |
| in_data | input | 19 | Raw measurement code |
| out_valid | output | 1 | `out_data` carries a corrected sample |
| out_data | output | 19 | Corrected measurement code |

## Verification
A corrupted table entry or a wrong index slice shows up as a mismatch on the sample of that bin two cycles after it enters. For this reason the sweep visits every bin under several upper-bit patterns, including the all-zero and all-one extremes where clamping applies. A misaligned valid pipeline or a write/read ordering error shows up on the very next sample. It is exposed by back-to-back streams that write an entry while a sample for the same bin is entering, and by streams broken by idle gaps.

// File: rtl/inl_pkg.sv
package inl_pkg;
  // default geometry for a 40 MHz reference with ~97.66 ps bins
  localparam int DEF_DATA_W = 19;  // measurement word
  localparam int DEF_IDX_W  = 8;   // bins per reference period = 2**IDX_W
  localparam int DEF_COEF_W = 8;   // signed offset width
  localparam int DEF_FRAC_W = 4;   // fractional bits of an offset
endpackage

// File: rtl/inl_coef_table.sv
module inl_coef_table #(
  parameter int IDX_W  = inl_pkg::DEF_IDX_W,
  parameter int COEF_W = inl_pkg::DEF_COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [COEF_W-1:0] wr_coef,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [COEF_W-1:0] rd_coef
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COEF_W-1:0] entry_q [DEPTH];

  // write and registered read share an edge: the read returns the old entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (wr_en) begin
      entry_q[wr_addr] <= wr_coef;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_coef <= '0;
    else if (rd_en)  rd_coef <= entry_q[rd_addr];
  end
endmodule

// File: rtl/inl_adjust.sv
module inl_adjust #(
  parameter int DATA_W = inl_pkg::DEF_DATA_W,
  parameter int COEF_W = inl_pkg::DEF_COEF_W,
  parameter int FRAC_W = inl_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_bypass,
  input  logic [DATA_W-1:0] s_raw,
  input  logic [COEF_W-1:0] s_coef,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data
);
  localparam int SUM_W = DATA_W + FRAC_W + 2;
  localparam logic signed [SUM_W-1:0] HALF     = SUM_W'(1) << (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'({DATA_W{1'b1}});

  // fixed-point add, round half up, clamp to [0, 2**DATA_W-1]
  function automatic logic [DATA_W-1:0] apply_coef(
    input logic [DATA_W-1:0] raw,
    input logic [COEF_W-1:0] coef
  );
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] q;
    acc = $signed({2'b00, raw, {FRAC_W{1'b0}}})
        + $signed({{(SUM_W-COEF_W){coef[COEF_W-1]}}, coef})
        + HALF;
    q = acc >>> FRAC_W;
    if (q[SUM_W-1])        return '0;
    else if (q > CODE_MAX) return '1;
    else                   return q[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] fixed_code;
  always_comb fixed_code = apply_coef(s_raw, s_coef);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_bypass ? s_raw : fixed_code;
    end
  end
endmodule

// File: rtl/inl_corrector.sv
module inl_corrector #(
  parameter int DATA_W = inl_pkg::DEF_DATA_W,
  parameter int IDX_W  = inl_pkg::DEF_IDX_W,
  parameter int COEF_W = inl_pkg::DEF_COEF_W,
  parameter int FRAC_W = inl_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_addr,
  input  logic [COEF_W-1:0] tbl_wr_coef,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  // stage 1: table read alongside the registered sample
  logic              s1_valid;
  logic              s1_bypass;
  logic [DATA_W-1:0] s1_raw;
  logic [COEF_W-1:0] s1_coef;

  inl_coef_table #(.IDX_W(IDX_W), .COEF_W(COEF_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_coef (tbl_wr_coef),
    .rd_en   (in_valid),
    .rd_addr (in_data[IDX_W-1:0]),
    .rd_coef (s1_coef)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b0;
      s1_raw    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_bypass <= bypass;
        s1_raw    <= in_data;
      end
    end
  end

  // stage 2: add, round, clamp
  inl_adjust #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_adjust (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s1_valid),
    .s_bypass (s1_bypass),
    .s_raw    (s1_raw),
    .s_coef   (s1_coef),
    .m_valid  (out_valid),
    .m_data   (out_data)
  );
endmodule

// File: rtl/inl_corrector_chk.sv
module inl_corrector_chk #(
  parameter int DATA_W = inl_pkg::DEF_DATA_W,
  parameter int COEF_W = inl_pkg::DEF_COEF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s1_valid,
  input logic              s1_bypass,
  input logic [DATA_W-1:0] s1_raw,
  input logic [COEF_W-1:0] s1_coef,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  assert_valid_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  assert_valid_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  assert_bypass_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_bypass) |=> out_data == $past(s1_raw));
  assert_zero_coef_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_bypass && s1_coef == '0) |=> out_data == $past(s1_raw));
  assert_pos_coef_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_bypass && !s1_coef[COEF_W-1]) |=> out_data >= $past(s1_raw));
  assert_neg_coef_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_bypass && s1_coef[COEF_W-1]) |=> out_data <= $past(s1_raw));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_data));
endmodule

bind inl_corrector inl_corrector_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s1_valid  (s1_valid),
  .s1_bypass (s1_bypass),
  .s1_raw    (s1_raw),
  .s1_coef   (s1_coef),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_inl_corrector.sv
`timescale 1ns/1ps
module tb_inl_corrector;
  localparam int MAXC = (1 << 19) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [7:0]  tbl_wr_addr = '0;
  logic [7:0]  tbl_wr_coef = '0;
  logic        in_valid = 1'b0;
  logic [18:0] in_data = '0;
  logic        out_valid;
  logic [18:0] out_data;

  always #2.5 clk = ~clk;  // 200 MHz

  inl_corrector dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_coef(tbl_wr_coef),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int shadow [256];     // bench copy of the offsets, as integers
  bit    p0_v = 0, p1_v = 0;
  int    p0_e = 0, p1_e = 0;
  string p0_t = "", p1_t = "";
  int    last_out = 0;

  // reference arithmetic: exact integer floor division, then clamp
  function automatic int expect_code(int raw, int c, bit byp);
    int v, q;
    if (byp) return raw;
    v = raw * 16 + c + 8;
    if (v >= 0) q = v / 16;
    else        q = -((-v + 15) / 16);
    if (q < 0) q = 0;
    if (q > MAXC) q = MAXC;
    return q;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: check the sample from two steps ago, then drive this step
  task automatic step(bit v, int raw, bit byp, bit we, int wa, int wc, string tag);
    @(negedge clk);
    check("R2 out_valid", int'(out_valid), int'(p1_v));
    if (p1_v) begin
      check(p1_t, int'(out_data), p1_e);
      last_out = p1_e;
    end else begin
      check("R9 hold", int'(out_data), last_out);
    end
    p1_v = p0_v; p1_e = p0_e; p1_t = p0_t;
    in_valid    = v;
    in_data     = 19'(raw);
    bypass      = byp;
    tbl_wr_en   = we;
    tbl_wr_addr = 8'(wa);
    tbl_wr_coef = 8'(wc);
    p0_v = v;
    p0_e = expect_code(raw & MAXC, shadow[raw & 255], byp);  // old entry (R8)
    p0_t = tag;
    if (we) shadow[wa] = wc;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #500000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset out_data", int'(out_data), 0);

    // R1: zero table passes raw codes
    for (int i = 0; i < 40; i++) step(1, (i * 13109 + 77) & MAXC, 0, 0, 0, 0, "R1 zero table");
    idle(2);

    // load every bin with a distinct offset covering -128..127
    for (int i = 0; i < 256; i++) step(0, 0, 0, 1, i, ((i * 73 + 5) % 256) - 128, "load");
    idle(2);

    // R3: every bin under a middle upper pattern; R4: more upper patterns
    for (int i = 0; i < 256; i++) step(1, (1 << 8) | i, 0, 0, 0, 0, "R3 bin index");
    for (int i = 0; i < 256; i++) step(1, (1000 << 8) | i, 0, 0, 0, 0, "R4 rounding");
    for (int i = 0; i < 256; i++) step(1, (1365 << 8) | i, 0, 0, 0, 0, "R4 rounding");
    // R5: lowest codes, negative offsets clamp at zero
    for (int i = 0; i < 256; i++) step(1, i, 0, 0, 0, 0, "R5 clamp low");
    // R6: highest codes, positive offsets clamp at max
    for (int i = 0; i < 256; i++) step(1, (2047 << 8) | i, 0, 0, 0, 0, "R6 clamp high");
    idle(2);

    // R7: bypass toggled per sample
    for (int i = 0; i < 60; i++)
      step(1, (i * 7919 + 3) & MAXC, (i % 3) == 0, 0, 0, 0, "R7 bypass");
    idle(2);

    // R8: writes to bin 9 while samples of bin 9 stream through
    step(1, (5 << 8) | 9, 0, 0, 0, 0, "R8 before write");
    step(1, (5 << 8) | 9, 0, 1, 9, 100, "R8 same edge as write");
    step(1, (5 << 8) | 9, 0, 0, 0, 0, "R8 after write");
    step(1, (6 << 8) | 9, 0, 1, 9, -100, "R8 same edge as write");
    step(1, (6 << 8) | 9, 0, 0, 0, 0, "R8 after write");
    step(0, 0, 0, 1, 9, 7, "R8 idle write");
    step(1, (7 << 8) | 9, 0, 0, 0, 0, "R8 after idle write");
    idle(2);

    // R2/R9: broken stream with garbage on idle cycles
    for (int i = 0; i < 80; i++) begin
      if ((i % 4) == 1 || (i % 7) == 3)
        step(0, (i * 4099) & MAXC, 1, 0, 0, 0, "R9 gap");
      else
        step(1, (i * 2731 + 11) & MAXC, 0, 0, 0, 0, "R2 gapped stream");
    end
    idle(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule